// File: doc/BRIEF.md
# Wrapping Block Counter Context

This unit keeps the 128-bit running counter that a counter-mode cipher datapath encrypts once per data block. The host loads a starting counter and a wrap width M through a word-addressed context port. Each pulse on the block-advance strobe then steps the counter by one. Only the low M bits take part in the count: they wrap modulo 2^M. The bits above them never change, and a carry out of the top counted bit is dropped. M may be any multiple of 8 from 8 to 128. The current counter value drives a 128-bit output that feeds an external cipher core. Keystream generation and the XOR with data lie outside this block.

The context port has two word maps, and the `map_full` input picks one of them. In the compact map, words 1 and 2 hold the low and high counter halves and word 3 holds M. In the wide map, words 1 to 4 are placeholders that must be written with zero, and words 5, 6 and 7 hold the low half, the high half and M. Each 64-bit word is decoded into a role by an enumerated decoder: `ROLE_NONE`, `ROLE_ZERO`, `ROLE_CTR_LO`, `ROLE_CTR_HI` or `ROLE_MOD`. A unique case on that role selects what a write does and what a read returns.

Top module: `ctr_ctx_unit`

## Requirements
- R1: After reset the counter output is zero, M is 128, and both error outputs are low.
- R2: With `blk_adv` high and no write, the next clock edge sets counter bits [M-1:0] to their old value plus one, modulo 2^M. Bits [127:M] stay unchanged.
- R3: The counter output shows the value before the increment of the current block. While `blk_adv` is held high, the counter takes one step per clock cycle. With `blk_adv` low and no write, the counter holds.
- R4: A write of a legal M to the modulus word updates M, and M reads back zero-extended in bits [7:0] of that word. The upper bits of the written data are ignored.
- R5: A modulus value of 0, above 128 or not a multiple of 8 is rejected. M keeps its old value, and `mod_err` is high for exactly the one cycle after the write edge.
- R6: With `map_full` = 0, word 1 is counter bits [63:0], word 2 is counter bits [127:64] and word 3 is M. Each of these words can be both written and read.
- R7: With `map_full` = 1, word 5 is counter bits [63:0], word 6 is counter bits [127:64] and word 7 is M. Words 1 to 4 read as zero.
- R8: With `map_full` = 1, a nonzero write to words 1 to 4 pulses `ctx_err` for the one cycle after the write edge and changes no state. A zero write to those words raises no error.
- R9: A write to a word with no role is ignored and that word reads as zero. Word 0 has no role in either map, and words 4 to 7 have no role when `map_full` = 0.
- R10: If a counter word is written in the same cycle that `blk_adv` is high, the written value is loaded and that advance is dropped.
- R11: The `map_full` input selects the map combinationally for every access. Changing it alters no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_full | input | 1 | 1 selects the wide map (words 5-7), 0 selects the compact map (words 1-3) |
| reg_we | input | 1 | Context word write enable |
| reg_addr | input | 3 | Context word index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the addressed word (combinational) |
| blk_adv | input | 1 | One block processed: step the counter |
| ctr_out | output | 128 | Current counter value presented to the cipher |
| mod_err | output | 1 | One-cycle pulse when an illegal M is rejected |
| ctx_err | output | 1 | One-cycle pulse when a placeholder word is written nonzero in the wide map |

## Verification
`reg_rdata` is combinational, so the bench samples it 1 ns after it sets the address, away from the clock edge. A write, an advance or an error pulse registers on the rising edge after the input is driven. The bench drives every input on a falling edge and checks the result on the next falling edge, which is exactly one register stage later. To confirm that each error lasts one cycle, the bench checks the error output once more on the falling edge after that and expects it low. The sweep steps through every legal M. For each one it computes the expected wrap arithmetically from a counter value loaded two steps below the wrap point.

// File: rtl/ctr_ctx_pkg.sv
package ctr_ctx_pkg;
    typedef enum logic [2:0] {
        ROLE_NONE,
        ROLE_ZERO,
        ROLE_CTR_LO,
        ROLE_CTR_HI,
        ROLE_MOD
    } word_role_e;
endpackage

// File: rtl/ctx_map_decode.sv
module ctx_map_decode
    import ctr_ctx_pkg::*;
(
    input  logic       map_full,
    input  logic [2:0] addr,
    output word_role_e role
);
    always_comb begin
        role = ROLE_NONE;
        if (map_full) begin
            unique case (addr)
                3'd1, 3'd2, 3'd3, 3'd4: role = ROLE_ZERO;
                3'd5:                   role = ROLE_CTR_LO;
                3'd6:                   role = ROLE_CTR_HI;
                3'd7:                   role = ROLE_MOD;
                default:                role = ROLE_NONE;
            endcase
        end else begin
            unique case (addr)
                3'd1:    role = ROLE_CTR_LO;
                3'd2:    role = ROLE_CTR_HI;
                3'd3:    role = ROLE_MOD;
                default: role = ROLE_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mod_check.sv
module mod_check #(
    parameter int CTR_W  = 128,
    parameter int LANE_W = 8,
    parameter int MW     = 8
) (
    input  logic [MW-1:0] m_i,
    output logic          legal_o
);
    logic [31:0] m_wide;
    assign m_wide  = 32'(m_i);
    assign legal_o = (m_wide != 32'd0) &&
                     (m_wide <= 32'(CTR_W)) &&
                     ((m_wide % 32'(LANE_W)) == 32'd0);
endmodule

// File: rtl/ctr_wrap_inc.sv
module ctr_wrap_inc #(
    parameter int CTR_W  = 128,
    parameter int LANE_W = 8,
    parameter int MW     = 8
) (
    input  logic [CTR_W-1:0] ctr_i,
    input  logic [MW-1:0]    m_i,
    output logic [CTR_W-1:0] ctr_o
);
    localparam int LANES = CTR_W / LANE_W;

    logic [CTR_W-1:0] sum;
    logic [LANES-1:0] lane_on;

    assign sum = ctr_i + CTR_W'(1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_on[g] = (32'(m_i) >= 32'((g + 1) * LANE_W));
        assign ctr_o[g*LANE_W +: LANE_W] =
            lane_on[g] ? sum[g*LANE_W +: LANE_W] : ctr_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/ctr_ctx_unit.sv
module ctr_ctx_unit
    import ctr_ctx_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_full,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              blk_adv,
    output logic [2*WORD_W-1:0] ctr_out,
    output logic              mod_err,
    output logic              ctx_err
);
    localparam int CTR_W = 2 * WORD_W;
    localparam int MW    = $clog2(CTR_W + 1);

    word_role_e       role;
    logic [CTR_W-1:0] ctr_q, ctr_d, ctr_inc;
    logic [MW-1:0]    m_q, m_d, m_wr;
    logic             m_legal;
    logic             mod_err_q, ctx_err_q;
    logic             wr_lo, wr_hi, wr_mod, wr_zero_bad;

    ctx_map_decode u_dec (
        .map_full (map_full),
        .addr     (reg_addr),
        .role     (role)
    );

    assign m_wr = reg_wdata[MW-1:0];

    mod_check #(.CTR_W(CTR_W), .LANE_W(LANE_W), .MW(MW)) u_chk (
        .m_i     (m_wr),
        .legal_o (m_legal)
    );

    ctr_wrap_inc #(.CTR_W(CTR_W), .LANE_W(LANE_W), .MW(MW)) u_inc (
        .ctr_i (ctr_q),
        .m_i   (m_q),
        .ctr_o (ctr_inc)
    );

    always_comb begin
        wr_lo       = 1'b0;
        wr_hi       = 1'b0;
        wr_mod      = 1'b0;
        wr_zero_bad = 1'b0;
        unique case (role)
            ROLE_CTR_LO: wr_lo       = reg_we;
            ROLE_CTR_HI: wr_hi       = reg_we;
            ROLE_MOD:    wr_mod      = reg_we;
            ROLE_ZERO:   wr_zero_bad = reg_we && (reg_wdata != '0);
            ROLE_NONE:   ;
            default:     ;
        endcase
    end

    always_comb begin
        ctr_d = ctr_q;
        if (wr_lo)
            ctr_d = {ctr_q[CTR_W-1:WORD_W], reg_wdata};
        else if (wr_hi)
            ctr_d = {reg_wdata, ctr_q[WORD_W-1:0]};
        else if (blk_adv)
            ctr_d = ctr_inc;
        m_d = (wr_mod && m_legal) ? m_wr : m_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q     <= '0;
            m_q       <= MW'(CTR_W);
            mod_err_q <= 1'b0;
            ctx_err_q <= 1'b0;
        end else begin
            ctr_q     <= ctr_d;
            m_q       <= m_d;
            mod_err_q <= wr_mod && !m_legal;
            ctx_err_q <= wr_zero_bad;
        end
    end

    always_comb begin
        unique case (role)
            ROLE_CTR_LO: reg_rdata = ctr_q[WORD_W-1:0];
            ROLE_CTR_HI: reg_rdata = ctr_q[CTR_W-1:WORD_W];
            ROLE_MOD:    reg_rdata = {{(WORD_W-MW){1'b0}}, m_q};
            default:     reg_rdata = '0;
        endcase
    end

    assign ctr_out = ctr_q;
    assign mod_err = mod_err_q;
    assign ctx_err = ctx_err_q;

    logic [CTR_W-1:0] keep_mask;
    always_comb begin
        if (32'(m_q) >= 32'(CTR_W))
            keep_mask = '0;
        else
            keep_mask = ~((CTR_W'(1) << m_q) - CTR_W'(1));
    end

    p_upper_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_adv && !reg_we) |=> (((ctr_q ^ $past(ctr_q)) & $past(keep_mask)) == '0));

    p_adv_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_adv && !reg_we) |=> (ctr_q != $past(ctr_q)));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_adv && !reg_we) |=> $stable(ctr_q));

    p_mod_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q != '0) && (32'(m_q) <= 32'(CTR_W)) && ((32'(m_q) % 32'(LANE_W)) == 32'd0));

    p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mod_err |-> (m_q == $past(m_q)));

    p_ctx_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_err && !$past(blk_adv)) |-> $stable(ctr_q));

    p_err_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mod_err, ctx_err}));
endmodule

// File: tb/ctr_ctx_unit_test.sv
`timescale 1ns/1ps
module ctr_ctx_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         map_full = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [63:0]  reg_wdata = '0;
    logic [63:0]  reg_rdata;
    logic         blk_adv = 1'b0;
    logic [127:0] ctr_out;
    logic         mod_err, ctx_err;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctr_ctx_unit uut (
        .clk(clk), .rst_n(rst_n), .map_full(map_full),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .blk_adv(blk_adv), .ctr_out(ctr_out),
        .mod_err(mod_err), .ctx_err(ctx_err)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] step(input logic [127:0] c, input int m);
        logic [127:0] mask;
        mask = (m >= 128) ? '1 : ((128'(1) << m) - 128'(1));
        return (c & ~mask) | ((c + 128'(1)) & mask);
    endfunction

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic adv1();
        @(negedge clk);
        blk_adv = 1'b1;
        @(negedge clk);
        blk_adv = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [63:0]  r;
        logic [127:0] c, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 counter", ctr_out, '0);
        rd(3'd3, r); chk("R1 modulus", 128'(r), 128'd128);
        chk("R1 errors", {126'd0, mod_err, ctx_err}, '0);

        // R6 compact map write/read
        wr(3'd1, 64'h0123_4567_89AB_CDEF);
        wr(3'd2, 64'hFEDC_BA98_7654_3210);
        chk("R6 ctr_out", ctr_out, 128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF);
        rd(3'd1, r); chk("R6 word1", 128'(r), 128'h0123_4567_89AB_CDEF);
        rd(3'd2, r); chk("R6 word2", 128'(r), 128'hFEDC_BA98_7654_3210);

        // R2/R4/R3 sweep over every legal M
        for (int k = 1; k <= 16; k++) begin
            int m;
            logic [127:0] mask;
            m = k * 8;
            wr(3'd3, 64'hFF00_0000_0000_0000 | 64'(m));
            rd(3'd3, r); chk("R4 modulus readback", 128'(r), 128'(m));
            mask = (m >= 128) ? '1 : ((128'(1) << m) - 128'(1));
            c = (128'h5A3C_96E1_0F87_D24B_C3A5_6699_1E2D_4B78 & ~mask) | (mask - 128'(1));
            wr(3'd1, c[63:0]);
            wr(3'd2, c[127:64]);
            chk("R3 pre-increment value", ctr_out, c);
            adv1();
            e = step(c, m);
            chk("R2 step", ctr_out, e);
            adv1();
            e = step(e, m);
            chk("R2 wrap", ctr_out, e);
        end

        // R3 held strobe: one step per cycle, then hold
        wr(3'd3, 64'd16);
        wr(3'd1, 64'h0000_0000_0000_FFFD);
        wr(3'd2, 64'h1111_2222_3333_4444);
        c = ctr_out;
        @(negedge clk);
        blk_adv = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            c = step(c, 16);
            chk("R3 consecutive step", ctr_out, c);
        end
        blk_adv = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 idle hold", ctr_out, c);

        // R5 illegal M values
        foreach (r[i]) begin end
        begin
            logic [63:0] bad [4];
            bad[0] = 64'd0; bad[1] = 64'd4; bad[2] = 64'd136; bad[3] = 64'd255;
            for (int i = 0; i < 4; i++) begin
                wr(3'd3, bad[i]);
                chk("R5 mod_err pulse", 128'(mod_err), 128'd1);
                rd(3'd3, r); chk("R5 M kept", 128'(r), 128'd16);
                @(negedge clk);
                chk("R5 mod_err single cycle", 128'(mod_err), 128'd0);
            end
        end

        // R9 unmapped words in compact map
        c = ctr_out;
        wr(3'd5, 64'hDEAD_BEEF_DEAD_BEEF);
        wr(3'd0, 64'hCAFE_CAFE_CAFE_CAFE);
        wr(3'd7, 64'd8);
        chk("R9 counter untouched", ctr_out, c);
        rd(3'd3, r); chk("R9 M untouched", 128'(r), 128'd16);
        rd(3'd5, r); chk("R9 word5 reads zero", 128'(r), '0);
        rd(3'd0, r); chk("R9 word0 reads zero", 128'(r), '0);
        chk("R9 no error", {126'd0, mod_err, ctx_err}, '0);

        // R7/R11 wide map
        map_full = 1'b1;
        #1;
        chk("R11 map switch keeps counter", ctr_out, c);
        rd(3'd5, r); chk("R11 word5 is low half", 128'(r), 128'(c[63:0]));
        rd(3'd1, r); chk("R7 word1 zero", 128'(r), '0);
        rd(3'd3, r); chk("R7 word3 zero", 128'(r), '0);
        wr(3'd5, 64'h0000_0000_0000_00FF);
        wr(3'd6, 64'h8000_0000_0000_0001);
        wr(3'd7, 64'd8);
        chk("R7 counter load", ctr_out, 128'h8000_0000_0000_0001_0000_0000_0000_00FF);
        rd(3'd7, r); chk("R7 word7 modulus", 128'(r), 128'd8);
        rd(3'd6, r); chk("R7 word6 high half", 128'(r), 128'h8000_0000_0000_0001);
        adv1();
        chk("R7 wrap at M=8", ctr_out, 128'h8000_0000_0000_0001_0000_0000_0000_0000);

        // R8 placeholder words
        c = ctr_out;
        wr(3'd2, 64'h1);
        chk("R8 ctx_err pulse", 128'(ctx_err), 128'd1);
        chk("R8 state unchanged", ctr_out, c);
        @(negedge clk);
        chk("R8 ctx_err single cycle", 128'(ctx_err), 128'd0);
        wr(3'd4, 64'h0);
        chk("R8 zero write no error", 128'(ctx_err), 128'd0);
        rd(3'd7, r); chk("R8 M unchanged", 128'(r), 128'd8);

        // R10 write beats advance
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 64'h0000_0000_0000_0042; blk_adv = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; blk_adv = 1'b0;
        chk("R10 write wins", ctr_out, 128'h8000_0000_0000_0001_0000_0000_0000_0042);

        map_full = 1'b0;
        #1;
        rd(3'd1, r); chk("R11 compact word1 after switch", 128'(r), 128'h42);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule